// File: doc/BRIEF.md
# Saturating multiply-accumulate unit

This block is the multiply-accumulate engine of a 32-bit processor core. It keeps a 64-bit accumulator, exposed as a high word and a low word. A start strobe captures two 32-bit register operands, a mode select and a saturation enable. One cycle later the signed product is added into the accumulator, and a one-cycle done pulse marks the update.

There are two operand modes. Long mode multiplies the full 32-bit operands. Word mode multiplies only their low 16-bit halves. When saturation is enabled, each mode applies its own clamp:
- Long mode limits the accumulator to a signed 48-bit range.
- Word mode limits the result to a signed 32-bit range, and on overflow it sets the high word to 1 as a marker.

Software can also clear the accumulator or load either word directly.

Top module: `mac_sat_unit`

## Requirements
- R1: With `mode_word_i`=0 (long mode), the 32-bit operands are multiplied as signed values, and the 64-bit product is added to the accumulator {acc_hi, acc_lo}.
- R2: With `mode_word_i`=1 (word mode), only bits [15:0] of each operand are used. They are multiplied as signed 16-bit values, and the product is sign-extended and added to the 64-bit accumulator.
- R3: When `sat_en_i` is 0 at start, the stored result is the 64-bit sum taken modulo 2^64, in either mode.
- R4: In long mode with saturation, a true sum below -2^47 stores hi=0xFFFF8000 and lo=0x00000000. A true sum above 2^47-1 stores hi=0x00007FFF and lo=0xFFFFFFFF. A sum in range is stored unchanged.
- R5: In word mode with saturation, a true sum below -2^31 stores lo=0x80000000, and a true sum above 2^31-1 stores lo=0x7FFFFFFF. In both cases hi is set to 0x00000001. A sum in range is stored as the full 64-bit sum.
- R6: Operands, mode and saturation enable are captured at the clock edge where `start_i` is sampled high while the unit is idle. The accumulator updates at the following edge. `done_o` is high for exactly the one cycle after that update.
- R7: A `start_i` sampled while an accumulate is pending (the cycle after an accepted start) is ignored.
- R8: `clr_i` zeroes both words at the next edge. It overrides a start or direct write in the same cycle, and it cancels a pending accumulate, so no done pulse follows.
- R9: `hi_wr_i`/`lo_wr_i` load their word at the next edge while the unit is idle. A load in the same cycle as a start is used by that accumulate. Loads presented while an accumulate is pending are ignored.
- R10: After reset, both words are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one multiply-accumulate |
| mode_word_i | input | 1 | 0 = long mode, 1 = word mode |
| sat_en_i | input | 1 | Saturation enable from the status register |
| clr_i | input | 1 | Zero the accumulator |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| hi_wr_i | input | 1 | Load the high word |
| hi_wdata_i | input | 32 | High word load value |
| lo_wr_i | input | 1 | Load the low word |
| lo_wdata_i | input | 32 | Low word load value |
| acc_hi_o | output | 32 | Accumulator bits [63:32] |
| acc_lo_o | output | 32 | Accumulator bits [31:0] |
| done_o | output | 1 | One-cycle pulse after an accumulate |

## Verification
The accumulator is fully visible at the ports, so a wrong product, sum or clamp shows on the outputs in the same cycle as the done pulse. A lost pending flag or captured mode instead shows up as a missing or extra done pulse, or as a word that changes one cycle late. Because every result feeds the next accumulate, an error persists across later results until a clear or load replaces it. The bench therefore compares both words after every operation rather than only at the end.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

    typedef enum logic {
        MODE_LONG = 1'b0,
        MODE_WORD = 1'b1
    } mac_mode_e;

    localparam int unsigned DEF_DATA_W     = 32;
    localparam int unsigned DEF_HALF_W     = 16;
    localparam int unsigned DEF_LONG_SAT_W = 48;

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_sat_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned HALF_W = DEF_HALF_W,
    localparam int unsigned ACC_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  mac_mode_e         mode,
    output logic [ACC_W-1:0]  prod
);

    logic [ACC_W-1:0] ext_a;
    logic [ACC_W-1:0] ext_b;

    // sign-extend the selected operand slice to full width; the low ACC_W
    // bits of the unsigned product then equal the signed product
    always_comb begin
        if (mode == MODE_WORD) begin
            ext_a = {{(ACC_W-HALF_W){op_a[HALF_W-1]}}, op_a[HALF_W-1:0]};
            ext_b = {{(ACC_W-HALF_W){op_b[HALF_W-1]}}, op_b[HALF_W-1:0]};
        end else begin
            ext_a = {{(ACC_W-DATA_W){op_a[DATA_W-1]}}, op_a};
            ext_b = {{(ACC_W-DATA_W){op_b[DATA_W-1]}}, op_b};
        end
        prod = ext_a * ext_b;
    end

endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_sat_pkg::*;
#(
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned LONG_SAT_W = DEF_LONG_SAT_W,
    localparam int unsigned ACC_W     = 2 * DATA_W,
    localparam int unsigned SUM_W     = ACC_W + 1
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] prod,
    input  mac_mode_e        mode,
    input  logic             sat_en,
    output logic [ACC_W-1:0] result
);

    localparam logic [ACC_W-1:0] LONG_POS =
        {{(ACC_W-LONG_SAT_W+1){1'b0}}, {(LONG_SAT_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] LONG_NEG =
        {{(ACC_W-LONG_SAT_W+1){1'b1}}, {(LONG_SAT_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] WORD_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] WORD_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] WORD_FLAG = DATA_W'(1);

    logic [SUM_W-1:0] sum;
    logic             neg;
    logic             long_fits;
    logic             word_fits;

    always_comb begin
        sum = {acc[ACC_W-1], acc} + {prod[ACC_W-1], prod};
        neg = sum[SUM_W-1];
        // a value fits a signed W-bit range when all bits from W-1 up agree
        long_fits = (sum[SUM_W-1:LONG_SAT_W-1] == '0) ||
                    (sum[SUM_W-1:LONG_SAT_W-1] == '1);
        word_fits = (sum[SUM_W-1:DATA_W-1] == '0) ||
                    (sum[SUM_W-1:DATA_W-1] == '1);

        result = sum[ACC_W-1:0];
        if (sat_en) begin
            if (mode == MODE_LONG) begin
                if (!long_fits) begin
                    result = neg ? LONG_NEG : LONG_POS;
                end
            end else begin
                if (!word_fits) begin
                    result = {WORD_FLAG, (neg ? WORD_NEG : WORD_POS)};
                end
            end
        end
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_sat_pkg::*;
#(
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned HALF_W     = DEF_HALF_W,
    parameter int unsigned LONG_SAT_W = DEF_LONG_SAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_word_i,
    input  logic              sat_en_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              hi_wr_i,
    input  logic [DATA_W-1:0] hi_wdata_i,
    input  logic              lo_wr_i,
    input  logic [DATA_W-1:0] lo_wdata_i,
    output logic [DATA_W-1:0] acc_hi_o,
    output logic [DATA_W-1:0] acc_lo_o,
    output logic              done_o
);

    localparam int unsigned ACC_W = 2 * DATA_W;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic              busy;
        logic              done;
        logic [DATA_W-1:0] op_a;
        logic [DATA_W-1:0] op_b;
        mac_mode_e         mode;
        logic              sat;
    } state_t;

    state_t state_d, state_q;

    logic [ACC_W-1:0] prod_w;
    logic [ACC_W-1:0] result_w;
    logic             busy_w;
    logic             cap_word_w;
    logic             cap_sat_w;

    mac_product #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) u_product (
        .op_a (state_q.op_a),
        .op_b (state_q.op_b),
        .mode (state_q.mode),
        .prod (prod_w)
    );

    mac_saturate #(
        .DATA_W     (DATA_W),
        .LONG_SAT_W (LONG_SAT_W)
    ) u_saturate (
        .acc    (state_q.acc),
        .prod   (prod_w),
        .mode   (state_q.mode),
        .sat_en (state_q.sat),
        .result (result_w)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (clr_i) begin
            state_d.acc  = '0;
            state_d.busy = 1'b0;
        end else if (state_q.busy) begin
            state_d.acc  = result_w;
            state_d.busy = 1'b0;
            state_d.done = 1'b1;
        end else begin
            if (hi_wr_i) begin
                state_d.acc[ACC_W-1:DATA_W] = hi_wdata_i;
            end
            if (lo_wr_i) begin
                state_d.acc[DATA_W-1:0] = lo_wdata_i;
            end
            if (start_i) begin
                state_d.busy = 1'b1;
                state_d.op_a = op_a_i;
                state_d.op_b = op_b_i;
                state_d.mode = mode_word_i ? MODE_WORD : MODE_LONG;
                state_d.sat  = sat_en_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_hi_o   = state_q.acc[ACC_W-1:DATA_W];
    assign acc_lo_o   = state_q.acc[DATA_W-1:0];
    assign done_o     = state_q.done;
    assign busy_w     = state_q.busy;
    assign cap_word_w = (state_q.mode == MODE_WORD);
    assign cap_sat_w  = state_q.sat;

endmodule

// File: rtl/mac_sat_chk.sv
module mac_sat_chk #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LONG_SAT_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              clr_i,
    input logic              hi_wr_i,
    input logic [DATA_W-1:0] hi_wdata_i,
    input logic [DATA_W-1:0] acc_hi_o,
    input logic [DATA_W-1:0] acc_lo_o,
    input logic              done_o,
    input logic              busy,
    input logic              cap_word,
    input logic              cap_sat
);

    localparam int unsigned TOP_LSB = LONG_SAT_W - DATA_W - 1;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    pending_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr_i) |=> done_o);

    // R7
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && !clr_i) |=> (busy && !done_o));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_hi_o == '0 && acc_lo_o == '0 && !done_o && !busy));

    // R9
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_i && !busy && !clr_i) |=> (acc_hi_o == $past(hi_wdata_i)));

    // R4
    long_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_sat && !cap_word) |->
            (acc_hi_o[DATA_W-1:TOP_LSB] == '0 || acc_hi_o[DATA_W-1:TOP_LSB] == '1));

    // R5
    word_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_sat && cap_word && acc_hi_o == DATA_W'(1)) |->
            (acc_lo_o == {1'b1, {(DATA_W-1){1'b0}}} ||
             acc_lo_o == {1'b0, {(DATA_W-1){1'b1}}}));

endmodule

bind mac_sat_unit mac_sat_chk #(
    .DATA_W     (DATA_W),
    .LONG_SAT_W (LONG_SAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .clr_i      (clr_i),
    .hi_wr_i    (hi_wr_i),
    .hi_wdata_i (hi_wdata_i),
    .acc_hi_o   (acc_hi_o),
    .acc_lo_o   (acc_lo_o),
    .done_o     (done_o),
    .busy       (busy_w),
    .cap_word   (cap_word_w),
    .cap_sat    (cap_sat_w)
);

// File: tb/tb_mac_sat_unit.sv
`timescale 1ns/1ps
module tb_mac_sat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, mode_word_i = 1'b0, sat_en_i = 1'b0, clr_i = 1'b0;
    logic [31:0] op_a_i = '0, op_b_i = '0;
    logic        hi_wr_i = 1'b0, lo_wr_i = 1'b0;
    logic [31:0] hi_wdata_i = '0, lo_wdata_i = '0;
    logic [31:0] acc_hi_o, acc_lo_o;
    logic        done_o;

    int unsigned nvec = 0;
    int unsigned nfail = 0;
    bit          finished = 1'b0;
    logic [63:0] model = '0;

    always #2 clk = ~clk;

    mac_sat_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_word_i(mode_word_i),
        .sat_en_i(sat_en_i), .clr_i(clr_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .hi_wr_i(hi_wr_i), .hi_wdata_i(hi_wdata_i), .lo_wr_i(lo_wr_i),
        .lo_wdata_i(lo_wdata_i), .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o),
        .done_o(done_o)
    );

    localparam logic signed [64:0] LMAX = 65'sh0_0000_7FFF_FFFF_FFFF;
    localparam logic signed [64:0] LMIN = -LMAX - 65'sd1;
    localparam logic signed [64:0] WMAX = 65'sh0_0000_0000_7FFF_FFFF;
    localparam logic signed [64:0] WMIN = -WMAX - 65'sd1;

    function automatic logic [63:0] ref_mac(logic [63:0] acc, logic [31:0] a,
                                            logic [31:0] b, bit word, bit sat);
        longint pa, pb, p;
        logic signed [64:0] s;
        pa = word ? longint'($signed(a[15:0])) : longint'($signed(a));
        pb = word ? longint'($signed(b[15:0])) : longint'($signed(b));
        p  = pa * pb;
        s  = $signed({acc[63], acc}) + $signed({p[63], p});
        if (sat && !word) begin
            if (s > LMAX) return 64'h0000_7FFF_FFFF_FFFF;
            if (s < LMIN) return 64'hFFFF_8000_0000_0000;
        end
        if (sat && word) begin
            if (s > WMAX) return 64'h0000_0001_7FFF_FFFF;
            if (s < WMIN) return 64'h0000_0001_8000_0000;
        end
        return s[63:0];
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives one accumulate and checks both cycles
    task automatic do_mac(input logic [31:0] a, input logic [31:0] b,
                          input bit word, input bit sat, input string tag);
        logic [63:0] exp;
        exp = ref_mac(model, a, b, word, sat);
        op_a_i = a; op_b_i = b; mode_word_i = word; sat_en_i = sat; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = $urandom; op_b_i = $urandom; mode_word_i = $urandom; sat_en_i = $urandom;
        chk({63'd0, done_o}, 64'd0, {tag, " R6 no early done"});
        chk({acc_hi_o, acc_lo_o}, model, {tag, " R6 acc held while pending"});
        @(negedge clk);
        chk({63'd0, done_o}, 64'd1, {tag, " R6 done"});
        chk({acc_hi_o, acc_lo_o}, exp, tag);
        model = exp;
    endtask

    task automatic load(input logic [63:0] v);
        hi_wr_i = 1'b1; lo_wr_i = 1'b1; hi_wdata_i = v[63:32]; lo_wdata_i = v[31:0];
        @(negedge clk);
        hi_wr_i = 1'b0; lo_wr_i = 1'b0;
        model = v;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [63:0] exp;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk({acc_hi_o, acc_lo_o}, 64'd0, "R10 reset acc");
        chk({63'd0, done_o}, 64'd0, "R10 reset done");

        // R9 direct loads
        load(64'h1234_5678_9ABC_DEF0);
        chk({acc_hi_o, acc_lo_o}, model, "R9 direct load");

        // R1 long mode
        load(64'h0000_0001_0000_0000);
        do_mac(32'hFFFF_FFFD, 32'd5, 1'b0, 1'b0, "R1 long signed");
        do_mac(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R1 long min*min");

        // R2 word mode ignores upper halves
        load(64'd100);
        do_mac(32'hABCD_FFFE, 32'h1234_0007, 1'b1, 1'b0, "R2 word slice");

        // R3 wrap without saturation
        load(64'h7FFF_FFFF_FFFF_FFFF);
        do_mac(32'd1, 32'd1, 1'b0, 1'b0, "R3 long wrap");
        load(64'h0000_0000_7FFF_FFFF);
        do_mac(32'd1, 32'd1, 1'b1, 1'b0, "R3 word no sat");
        chk({acc_hi_o, acc_lo_o}, 64'h0000_0000_8000_0000, "R3 word no sat value");

        // R4 long saturation
        load(64'h0000_7FFF_FFFF_FFF0);
        do_mac(32'h100, 32'h1, 1'b0, 1'b1, "R4 long pos clamp");
        chk({acc_hi_o, acc_lo_o}, 64'h0000_7FFF_FFFF_FFFF, "R4 pos value");
        load(64'hFFFF_8000_0000_0005);
        do_mac(32'hFFFF_FFF0, 32'h1, 1'b0, 1'b1, "R4 long neg clamp");
        chk({acc_hi_o, acc_lo_o}, 64'hFFFF_8000_0000_0000, "R4 neg value");
        load(64'h0000_1000_0000_0000);
        do_mac(32'h7FFF_0000, 32'h10, 1'b0, 1'b1, "R4 in range");

        // R5 word saturation
        load(64'h0000_0000_7FFF_FFF0);
        do_mac(32'h0000_0100, 32'h0000_0001, 1'b1, 1'b1, "R5 word pos clamp");
        chk({acc_hi_o, acc_lo_o}, 64'h0000_0001_7FFF_FFFF, "R5 pos flag");
        load(64'hFFFF_FFFF_8000_0003);
        do_mac(32'h0000_FFF0, 32'h0000_0001, 1'b1, 1'b1, "R5 word neg clamp");
        chk({acc_hi_o, acc_lo_o}, 64'h0000_0001_8000_0000, "R5 neg flag");
        load(64'hFFFF_FFFF_FFFF_FFF0);
        do_mac(32'h0000_0004, 32'h0000_0002, 1'b1, 1'b1, "R5 in range full");

        // R7 start held through pending cycle is ignored
        load(64'd10);
        exp = ref_mac(model, 32'd3, 32'd4, 1'b0, 1'b0);
        op_a_i = 32'd3; op_b_i = 32'd4; mode_word_i = 1'b0; sat_en_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        op_a_i = 32'd1000; op_b_i = 32'd1000;
        @(negedge clk);
        start_i = 1'b0;
        chk({acc_hi_o, acc_lo_o}, exp, "R7 first result only");
        @(negedge clk);
        chk({63'd0, done_o}, 64'd0, "R7 no second done");
        chk({acc_hi_o, acc_lo_o}, exp, "R7 acc unchanged");
        model = exp;

        // R9 load during pending ignored; load with start used
        load(64'd50);
        hi_wr_i = 1'b0; lo_wr_i = 1'b1; lo_wdata_i = 32'd7;
        op_a_i = 32'd2; op_b_i = 32'd3; mode_word_i = 1'b0; sat_en_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; hi_wr_i = 1'b1; hi_wdata_i = 32'hDEAD_BEEF; lo_wdata_i = 32'd99;
        @(negedge clk);
        hi_wr_i = 1'b0; lo_wr_i = 1'b0;
        chk({acc_hi_o, acc_lo_o}, 64'd13, "R9 load ignored while pending");
        model = 64'd13;

        // R8 clear beats start and cancels pending
        load(64'h5555_5555_5555_5555);
        clr_i = 1'b1; start_i = 1'b1; hi_wr_i = 1'b1; hi_wdata_i = 32'hFFFF_FFFF;
        @(negedge clk);
        clr_i = 1'b0; start_i = 1'b0; hi_wr_i = 1'b0;
        chk({acc_hi_o, acc_lo_o}, 64'd0, "R8 clear over start");
        @(negedge clk);
        chk({63'd0, done_o}, 64'd0, "R8 no done after clear");
        load(64'd77);
        op_a_i = 32'd5; op_b_i = 32'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk({acc_hi_o, acc_lo_o}, 64'd0, "R8 cancel pending");
        chk({63'd0, done_o}, 64'd0, "R8 cancel done");
        model = 64'd0;

        // random mix (R1 R2 R3 R4 R5)
        for (int i = 0; i < 600; i++) begin
            int unsigned sel;
            sel = $urandom_range(0, 9);
            if (sel == 0) begin
                load({$urandom, $urandom});
            end else if (sel == 1) begin
                load({{17{1'b0}}, 15'h7FFF, 32'hFFFF_FF00} ^ 64'($urandom_range(0, 255)));
            end else begin
                logic [31:0] a, b;
                a = (sel == 2) ? 32'h7FFF_FFFF : $urandom;
                b = (sel == 3) ? 32'h8000_0000 : $urandom;
                do_mac(a, b, 1'($urandom), 1'($urandom), "R1 random accumulate");
            end
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule